// File: doc/BRIEF.md
# Single-Outstanding DMA Request Bridge

This block sits between a DMA requester and a memory-side controller. It takes read and write requests from an inbound request stream and passes each one to memory unchanged. It then blocks further requests until the reply for that transfer comes back. Only one transaction is ever in flight. The kind of reply the bridge expects is fixed by the busy state it entered: read data after a read, an acknowledge after a write.

Requests that arrive while a transfer is open are not taken and not lost. They stay at the head of the requester's queue, because the bridge holds its ready low. Replies are always taken. A reply that matches the open transfer completes it. Any other reply is thrown away and reported as a protocol error. A request whose type code is undefined is removed from the queue, is not forwarded, and is reported.

Top module: `dma_req_bridge`

## Requirements
- R1: After reset the bridge is idle. rd_done, wr_done, req_err and rsp_err are low. req_ready is high whenever mem_ready is high.
- R2: Type code 2'b00 on req_type is a read. When idle, a valid read drives mem_valid high with mem_type 2'b00. req_ready equals mem_ready in that cycle. A handshake on the request stream moves the bridge to busy-reading.
- R3: Type code 2'b01 on req_type is a write. When idle, a valid write drives mem_valid high with mem_type 2'b01. A handshake moves the bridge to busy-writing.
- R4: While mem_valid is high, mem_addr, mem_len and mem_data equal req_addr, req_len and req_data.
- R5: While busy, req_ready and mem_valid are low, so a pending request stays in its queue. The first idle cycle accepts it.
- R6: In busy-reading, a response with rsp_type 2'b00 (data) ends the transfer. rd_done is high for exactly the one cycle after the handshake, with rd_data equal to the accepted rsp_data, and the bridge is idle again.
- R7: In busy-writing, a response with rsp_type 2'b01 (acknowledge) ends the transfer. wr_done is high for exactly the one cycle after the handshake, and the bridge is idle again.
- R8: rsp_ready is always high. A legal response that does not match the state is discarded: an acknowledge in busy-reading, data in busy-writing, or any response while idle. rsp_err is high for the one cycle after it, no done output is raised, and the busy state is unchanged.
- R9: A response with rsp_type 2'b10 or 2'b11 is illegal. It is discarded with an rsp_err pulse in the following cycle, and the state is unchanged.
- R10: In idle, a request with req_type 2'b10 or 2'b11 is illegal. req_ready is high for it whatever mem_ready is. mem_valid stays low, req_err is high for the one cycle after the handshake, and the bridge stays idle.
- R11: While idle with mem_ready low, a legal request is not popped and the bridge stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request stream valid |
| req_ready | output | 1 | Request stream ready (pop) |
| req_type | input | 2 | Request type: 00 read, 01 write, others illegal |
| req_addr | input | AW | Request address |
| req_len | input | LW | Request length |
| req_data | input | DW | Request data block |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request ready |
| mem_type | output | 2 | Forwarded type |
| mem_addr | output | AW | Forwarded address |
| mem_len | output | LW | Forwarded length |
| mem_data | output | DW | Forwarded data block |
| rsp_valid | input | 1 | Response valid |
| rsp_ready | output | 1 | Response ready (always high) |
| rsp_type | input | 2 | Response type: 00 data, 01 acknowledge, others illegal |
| rsp_data | input | DW | Response data block |
| rd_done | output | 1 | One-cycle read completion pulse |
| rd_data | output | DW | Read data, valid with rd_done |
| wr_done | output | 1 | One-cycle write completion pulse |
| req_err | output | 1 | One-cycle pulse after an illegal request is dropped |
| rsp_err | output | 1 | One-cycle pulse after a response is discarded |

## Verification
The hardest case to reach from the ports is a response that arrives in the same cycle as a pending request. One variant is a stray response while idle, which happens at the same edge as the request moves the bridge to busy. The other is a matching reply while a request waits behind a busy state; that request must be taken on the very next cycle and no earlier. Directed sequences hold a request valid across the whole busy period and inject replies of every kind in that window. A long random run then gives request valid, mem_ready, response valid and the type codes independent odds. The type codes lean toward the reply the state expects, so completions and mismatches both occur often.

// File: rtl/dma_bridge_pkg.sv
package dma_bridge_pkg;

   localparam int TYPE_W = 2;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_BUSY_RD = 2'd1,
      ST_BUSY_WR = 2'd2
   } bridge_state_e;

   localparam logic [TYPE_W-1:0] RQ_READ  = 2'b00;
   localparam logic [TYPE_W-1:0] RQ_WRITE = 2'b01;
   localparam logic [TYPE_W-1:0] RS_DATA  = 2'b00;
   localparam logic [TYPE_W-1:0] RS_ACK   = 2'b01;

   function automatic logic type_legal(input logic [TYPE_W-1:0] t);
      return (t == 2'b00) || (t == 2'b01);
   endfunction

endpackage

// File: rtl/dbr_issue.sv
module dbr_issue
   import dma_bridge_pkg::*;
#(
   parameter int AW = 32,
   parameter int LW = 8,
   parameter int DW = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              is_idle,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [TYPE_W-1:0] req_type,
   input  logic [AW-1:0]     req_addr,
   input  logic [LW-1:0]     req_len,
   input  logic [DW-1:0]     req_data,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [TYPE_W-1:0] mem_type,
   output logic [AW-1:0]     mem_addr,
   output logic [LW-1:0]     mem_len,
   output logic [DW-1:0]     mem_data,
   output logic              fwd_rd,
   output logic              fwd_wr,
   output logic              req_err
);

   logic legal;
   logic take;

   always_comb begin
      legal     = type_legal(req_type);
      req_ready = is_idle && (mem_ready || !legal);
      mem_valid = is_idle && req_valid && legal;
      take      = req_valid && req_ready;
      fwd_rd    = take && (req_type == RQ_READ);
      fwd_wr    = take && (req_type == RQ_WRITE);
      mem_type  = req_type;
      mem_addr  = req_addr;
      mem_len   = req_len;
      mem_data  = req_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) req_err <= 1'b0;
      else        req_err <= take && !legal;
   end

   // R3: a forwarded transfer always pops the request in the same cycle
   a_r3_pop_with_fwd: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_ready) |-> (req_valid && req_ready));

   // R10: an illegal request never reaches memory
   a_r10_no_illegal_fwd: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> type_legal(mem_type));

endmodule

// File: rtl/dbr_complete.sv
module dbr_complete
   import dma_bridge_pkg::*;
#(
   parameter int DW = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bridge_state_e     state,
   input  logic              rsp_valid,
   output logic              rsp_ready,
   input  logic [TYPE_W-1:0] rsp_type,
   input  logic [DW-1:0]     rsp_data,
   output logic              done_hit,
   output logic              rd_done,
   output logic [DW-1:0]     rd_data,
   output logic              wr_done,
   output logic              rsp_err
);

   logic rd_hit, wr_hit;

   always_comb begin
      rsp_ready = 1'b1;
      rd_hit    = rsp_valid && (state == ST_BUSY_RD) && (rsp_type == RS_DATA);
      wr_hit    = rsp_valid && (state == ST_BUSY_WR) && (rsp_type == RS_ACK);
      done_hit  = rd_hit || wr_hit;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_done <= 1'b0;
         wr_done <= 1'b0;
         rsp_err <= 1'b0;
         rd_data <= '0;
      end else begin
         rd_done <= rd_hit;
         wr_done <= wr_hit;
         rsp_err <= rsp_valid && !done_hit;
         if (rd_hit) rd_data <= rsp_data;
      end
   end

   // R6: read completion only follows a data reply taken in busy-reading
   a_r6_rd_source: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |-> $past(rsp_valid && state == ST_BUSY_RD && rsp_type == RS_DATA));

   // R7: write completion only follows an acknowledge taken in busy-writing
   a_r7_wr_source: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |-> $past(rsp_valid && state == ST_BUSY_WR && rsp_type == RS_ACK));

   // R8: completion kinds and errors are mutually exclusive
   a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({rd_done, wr_done, rsp_err}) <= 1);

endmodule

// File: rtl/dbr_state.sv
module dbr_state
   import dma_bridge_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fwd_rd,
   input  logic          fwd_wr,
   input  logic          done_hit,
   output bridge_state_e state,
   output logic          is_idle
);

   bridge_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: begin
            if (fwd_rd)      nxt = ST_BUSY_RD;
            else if (fwd_wr) nxt = ST_BUSY_WR;
         end
         ST_BUSY_RD, ST_BUSY_WR: if (done_hit) nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
      is_idle = (state == ST_IDLE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   // R2: an accepted read enters busy-reading
   a_r2_enter_rd: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_rd |=> (state == ST_BUSY_RD));

   // R3: an accepted write enters busy-writing
   a_r3_enter_wr: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_wr |=> (state == ST_BUSY_WR));

   // R5: no request is taken while busy
   a_r5_busy_no_take: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE) |-> !(fwd_rd || fwd_wr));

endmodule

// File: rtl/dma_req_bridge.sv
module dma_req_bridge
   import dma_bridge_pkg::*;
#(
   parameter int AW = 32,
   parameter int LW = 8,
   parameter int DW = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_type,
   input  logic [AW-1:0]     req_addr,
   input  logic [LW-1:0]     req_len,
   input  logic [DW-1:0]     req_data,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [1:0]        mem_type,
   output logic [AW-1:0]     mem_addr,
   output logic [LW-1:0]     mem_len,
   output logic [DW-1:0]     mem_data,
   input  logic              rsp_valid,
   output logic              rsp_ready,
   input  logic [1:0]        rsp_type,
   input  logic [DW-1:0]     rsp_data,
   output logic              rd_done,
   output logic [DW-1:0]     rd_data,
   output logic              wr_done,
   output logic              req_err,
   output logic              rsp_err
);

   generate
      if (AW < 1) begin : g_bad_aw
         $error("dma_req_bridge: AW must be at least 1");
      end
      if (LW < 1) begin : g_bad_lw
         $error("dma_req_bridge: LW must be at least 1");
      end
      if (DW < 8) begin : g_bad_dw
         $error("dma_req_bridge: DW must be at least 8");
      end
   endgenerate

   bridge_state_e state;
   logic is_idle, fwd_rd, fwd_wr, done_hit;

   dbr_issue #(.AW(AW), .LW(LW), .DW(DW)) u_issue (
      .clk(clk), .rst_n(rst_n), .is_idle(is_idle),
      .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
      .req_addr(req_addr), .req_len(req_len), .req_data(req_data),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_type(mem_type),
      .mem_addr(mem_addr), .mem_len(mem_len), .mem_data(mem_data),
      .fwd_rd(fwd_rd), .fwd_wr(fwd_wr), .req_err(req_err)
   );

   dbr_state u_state (
      .clk(clk), .rst_n(rst_n), .fwd_rd(fwd_rd), .fwd_wr(fwd_wr),
      .done_hit(done_hit), .state(state), .is_idle(is_idle)
   );

   dbr_complete #(.DW(DW)) u_complete (
      .clk(clk), .rst_n(rst_n), .state(state),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_type(rsp_type),
      .rsp_data(rsp_data), .done_hit(done_hit), .rd_done(rd_done),
      .rd_data(rd_data), .wr_done(wr_done), .rsp_err(rsp_err)
   );

   // R8, R9: a discarded reply leaves a busy state untouched
   a_r8_discard_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_err && $past(state) != ST_IDLE) |-> (state == $past(state)));

   // R10: an illegal request leaves the bridge idle
   a_r10_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |-> (state == ST_IDLE));

endmodule

// File: tb/dma_req_bridge_tb.sv
module dma_req_bridge_tb;

   localparam int AW = 32;
   localparam int LW = 8;
   localparam int DW = 64;
   localparam int S_IDLE = 0, S_RD = 1, S_WR = 2;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n;
   logic req_valid, req_ready;
   logic [1:0] req_type;
   logic [AW-1:0] req_addr;
   logic [LW-1:0] req_len;
   logic [DW-1:0] req_data;
   logic mem_valid, mem_ready;
   logic [1:0] mem_type;
   logic [AW-1:0] mem_addr;
   logic [LW-1:0] mem_len;
   logic [DW-1:0] mem_data;
   logic rsp_valid, rsp_ready;
   logic [1:0] rsp_type;
   logic [DW-1:0] rsp_data;
   logic rd_done, wr_done, req_err, rsp_err;
   logic [DW-1:0] rd_data;

   int checks = 0;
   int errors = 0;
   int model_st = S_IDLE;
   bit finished = 0;

   dma_req_bridge #(.AW(AW), .LW(LW), .DW(DW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
      .req_addr(req_addr), .req_len(req_len), .req_data(req_data),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_type(mem_type),
      .mem_addr(mem_addr), .mem_len(mem_len), .mem_data(mem_data),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_type(rsp_type),
      .rsp_data(rsp_data), .rd_done(rd_done), .rd_data(rd_data),
      .wr_done(wr_done), .req_err(req_err), .rsp_err(rsp_err)
   );

   task automatic chk(input string tag, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic bit legal(input logic [1:0] t);
      return t == 2'b00 || t == 2'b01;
   endfunction

   function automatic bit exp_ready(input int st, input logic [1:0] t, input bit mr);
      return st == S_IDLE && (mr || !legal(t));
   endfunction

   function automatic bit rsp_match(input int st, input logic [1:0] t);
      return (st == S_RD && t == 2'b00) || (st == S_WR && t == 2'b01);
   endfunction

   task automatic step(input bit rv, input logic [1:0] rt, input logic [AW-1:0] ra,
                       input logic [LW-1:0] rl, input logic [DW-1:0] rd, input bit mr,
                       input bit sv, input logic [1:0] st, input logic [DW-1:0] sd);
      bit er, take, hit;
      string tg;
      int nst;
      @(negedge clk);
      req_valid = rv; req_type = rt; req_addr = ra; req_len = rl; req_data = rd;
      mem_ready = mr; rsp_valid = sv; rsp_type = st; rsp_data = sd;
      #1;
      er = exp_ready(model_st, rt, mr);
      if (model_st != S_IDLE) tg = "R5";
      else if (!legal(rt)) tg = "R10";
      else if (!mr) tg = "R11";
      else tg = (rt == 2'b00) ? "R2" : "R3";
      chk(tg, "req_ready", req_ready, er);
      chk(tg, "mem_valid", mem_valid, model_st == S_IDLE && rv && legal(rt));
      if (model_st == S_IDLE && rv && legal(rt)) begin
         chk(tg, "mem_type", mem_type, rt);
         chk("R4", "mem_addr", mem_addr, ra);
         chk("R4", "mem_len", mem_len, rl);
         chk("R4", "mem_data", mem_data, rd);
      end
      chk("R8", "rsp_ready", rsp_ready, 1'b1);
      take = rv && er;
      hit = sv && rsp_match(model_st, st);
      nst = model_st;
      if (model_st == S_IDLE && take && legal(rt)) nst = (rt == 2'b00) ? S_RD : S_WR;
      else if (hit) nst = S_IDLE;
      @(posedge clk);
      #1;
      chk("R6", "rd_done", rd_done, hit && model_st == S_RD);
      if (hit && model_st == S_RD) chk("R6", "rd_data", rd_data, sd);
      chk("R7", "wr_done", wr_done, hit && model_st == S_WR);
      chk("R10", "req_err", req_err, take && !legal(rt));
      chk(legal(st) ? "R8" : "R9", "rsp_err", rsp_err, sv && !hit);
      model_st = nst;
   endtask

   task automatic idle_inputs();
      step(0, 2'b00, '0, '0, '0, 1, 0, 2'b00, '0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 0;
      req_valid = 0; req_type = 0; req_addr = 0; req_len = 0; req_data = 0;
      mem_ready = 1; rsp_valid = 0; rsp_type = 0; rsp_data = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      #1;
      // R1: reset state
      chk("R1", "rd_done", rd_done, 0);
      chk("R1", "wr_done", wr_done, 0);
      chk("R1", "req_err", req_err, 0);
      chk("R1", "rsp_err", rsp_err, 0);
      chk("R1", "req_ready", req_ready, 1);
      chk("R1", "mem_valid", mem_valid, 0);

      // R2, R6: read then data reply; request held behind busy (R5)
      step(1, 2'b00, 32'h1000, 8'd16, 64'h1111, 1, 0, 0, 0);
      step(1, 2'b01, 32'h2000, 8'd4, 64'h2222, 1, 0, 0, 0);
      step(1, 2'b01, 32'h2000, 8'd4, 64'h2222, 1, 1, 2'b01, 64'h9); // R8 ack in busy-read
      step(1, 2'b01, 32'h2000, 8'd4, 64'h2222, 1, 1, 2'b11, 64'h9); // R9 illegal reply
      step(1, 2'b01, 32'h2000, 8'd4, 64'h2222, 1, 1, 2'b00, 64'hCAFE_F00D_1234_5678);
      // R5: waiting write accepted on the first idle cycle, R3
      step(1, 2'b01, 32'h2000, 8'd4, 64'h2222, 1, 0, 0, 0);
      step(0, 2'b00, 0, 0, 0, 1, 1, 2'b00, 64'h5); // R8 data in busy-write
      step(0, 2'b00, 0, 0, 0, 1, 1, 2'b01, 64'h0); // R7
      // R8: reply while idle
      step(0, 2'b00, 0, 0, 0, 1, 1, 2'b01, 64'h0);
      // R11: memory not ready
      step(1, 2'b00, 32'h3000, 8'd1, 64'h3, 0, 0, 0, 0);
      step(1, 2'b00, 32'h3000, 8'd1, 64'h3, 0, 0, 0, 0);
      // R10: illegal request with mem_ready low
      step(1, 2'b10, 32'h4000, 8'd2, 64'h4, 0, 0, 0, 0);
      step(1, 2'b11, 32'h4000, 8'd2, 64'h4, 1, 0, 0, 0);
      // stray reply in the same cycle a read is accepted
      step(1, 2'b00, 32'h5000, 8'd8, 64'h5, 1, 1, 2'b00, 64'h77);
      step(0, 2'b00, 0, 0, 0, 1, 1, 2'b00, 64'hABCD);
      idle_inputs();

      // constrained random
      for (int i = 0; i < 4000; i++) begin
         logic [1:0] rt, st;
         int p = $urandom_range(0, 9);
         rt = (p < 8) ? 2'($urandom_range(0, 1)) : 2'($urandom_range(2, 3));
         p = $urandom_range(0, 9);
         if (p < 6) st = (model_st == S_WR) ? 2'b01 : 2'b00;
         else if (p < 9) st = (model_st == S_WR) ? 2'b00 : 2'b01;
         else st = 2'($urandom_range(2, 3));
         step($urandom_range(0, 3) != 0, rt, $urandom, 8'($urandom),
              {$urandom, $urandom}, $urandom_range(0, 3) != 0,
              $urandom_range(0, 2) == 0, st, {$urandom, $urandom});
      end
      idle_inputs();

      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule